// File: doc/BRIEF.md
# Per-queue descriptor credit gate

This block sits between a packet source and a DMA engine's card-to-host streaming path. The engine's shared stream-ready signal does not stall the source when a single queue's descriptor ring runs dry, so packets for that queue are lost without notice. The gate avoids this by keeping a credit count for every queue. Each credit stands for one descriptor, and one descriptor holds a packet of up to 4096 bytes. The counts are fed by status broadcasts from the engine's traffic-manager port. Those broadcasts arrive when a queue is brought up or when software advances that queue's producer index.

Before the source sends a packet, it presents a request with the packet's queue number. The gate reads that queue's count. If the count is non-zero, the gate answers with a grant and takes one credit. If the count is zero, it answers with a deny, which tells the source that the queue's credit is exhausted. Broadcasts that carry host-to-card or non-streaming status have no effect. A broadcast with its enable bit low marks the queue as invalidated and zeroes its count.

The counts live in a block-RAM style memory with one word per queue. The memory is read one cycle after the inputs are sampled and written one cycle later. Results are forwarded so that operations arriving back to back on the same queue see each other. When a credit update and an accepted request fall in the same cycle, they must name the same queue, and both are folded into one read-modify-write.

Top module: `c2h_credit_gate`

## Requirements
- R1: After reset every queue holds zero credit, gnt_valid and deny_valid are low, and the first request to any queue is denied.
- R2: An update with upd_valid=1, upd_c2h=1, upd_stream=1 and upd_enable=1 adds upd_avail to the credit of queue upd_qid. The sum saturates at 2^CRED_W-1 (65535 by default) and does not wrap.
- R3: An update with upd_c2h=0 or upd_stream=0 changes no credit.
- R4: An applicable update (upd_c2h=1, upd_stream=1) with upd_enable=0 sets the queue's credit to zero.
- R5: A request is accepted when req_valid and req_ready are both high at a rising edge. Exactly one of gnt_valid or deny_valid is then high for one cycle after the second following rising edge, with rsp_qid equal to the accepted req_qid.
- R6: An accepted request is granted if and only if its queue's credit is non-zero. The credit compared is the value before any update in the same cycle. A grant lowers that queue's credit by one.
- R7: A denied request leaves every credit unchanged.
- R8: req_ready is low exactly when an applicable update names a queue other than req_qid. A request that is not accepted produces no response and changes no credit.
- R9: An applicable update and an accepted request on the same queue in the same cycle are both applied. The new credit is the saturated sum minus one if the request is granted and upd_enable=1, and zero if upd_enable=0.
- R10: Operations on the same queue in consecutive cycles each see the result of the one before. N back-to-back requests to a queue holding N credits are all granted, and the next one is denied.
- R11: gnt_valid and deny_valid are never high together, and neither is high unless a request was accepted two edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Credit status broadcast present |
| upd_qid | input | $clog2(NUM_Q) | Queue named by the broadcast |
| upd_avail | input | CRED_W | Newly available descriptor count |
| upd_c2h | input | 1 | 1 = card-to-host direction, 0 = host-to-card |
| upd_stream | input | 1 | 1 = streaming queue |
| upd_enable | input | 1 | 1 = queue live, 0 = queue invalidated |
| req_valid | input | 1 | Packet send request |
| req_qid | input | $clog2(NUM_Q) | Queue of the packet |
| req_ready | output | 1 | Request can be accepted this cycle |
| gnt_valid | output | 1 | Packet may be sent; one credit taken |
| deny_valid | output | 1 | Queue has no credit; packet must wait |
| rsp_qid | output | $clog2(NUM_Q) | Queue the response refers to |

## Verification
On every cycle, the assertions check that a grant and a deny never coincide and that each accepted request gets exactly one response two edges later, carrying its own queue number. They also check that no response appears unless a request was accepted, and that the outputs are quiet right after reset. Whether a response is the right one depends on the credit history of each queue. Only the bench's scoreboard and its credit model can judge that. This covers saturation, ignored and invalidating broadcasts, same-cycle merges, arbitration stalls and back-to-back forwarding.

// File: rtl/credit_gate_pkg.sv
package credit_gate_pkg;

  // Outcome of one evaluated request.
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_GRANT = 2'd1,
    RSP_DENY  = 2'd2
  } rsp_e;

endpackage

// File: rtl/credit_ram.sv
// One-write, one-read memory with a registered read port (block RAM shape).
module credit_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/credit_fwd.sv
// Picks the current credit of a queue: zero if never written since reset,
// the value written on the last edge if it hits, else the memory word.
module credit_fwd #(
  parameter int CW = 16,
  parameter int QW = 3
) (
  input  logic          live,
  input  logic [QW-1:0] qid,
  input  logic [CW-1:0] rd_data,
  input  logic          fwd_en,
  input  logic [QW-1:0] fwd_qid,
  input  logic [CW-1:0] fwd_data,
  output logic [CW-1:0] base
);

  always_comb begin
    if (!live)                          base = '0;
    else if (fwd_en && fwd_qid == qid)  base = fwd_data;
    else                                base = rd_data;
  end

endmodule

// File: rtl/credit_merge.sv
// Folds a credit update and a request into one write.
module credit_merge
  import credit_gate_pkg::*;
#(
  parameter int CW = 16,
  parameter int QW = 3
) (
  input  logic          req,
  input  logic          app,
  input  logic          en,
  input  logic [QW-1:0] uq,
  input  logic [QW-1:0] rq,
  input  logic [CW-1:0] avail,
  input  logic [CW-1:0] u_base,
  input  logic [CW-1:0] r_base,
  output rsp_e          kind,
  output logic          wr_en,
  output logic [QW-1:0] wr_q,
  output logic [CW-1:0] wr_d
);

  logic          grant;
  logic [CW:0]   sum;
  logic [CW-1:0] upd_val;

  always_comb begin
    grant   = req && (r_base != '0);
    sum     = {1'b0, u_base} + {1'b0, avail};
    upd_val = sum[CW] ? '1 : sum[CW-1:0];
    if (!en) upd_val = '0;

    wr_en = 1'b0;
    wr_q  = rq;
    wr_d  = r_base - CW'(1);
    if (app) begin
      wr_en = 1'b1;
      wr_q  = uq;
      wr_d  = upd_val;
      if (grant && uq == rq && en) wr_d = upd_val - CW'(1);
    end else if (grant) begin
      wr_en = 1'b1;
    end

    if (!req)       kind = RSP_NONE;
    else if (grant) kind = RSP_GRANT;
    else            kind = RSP_DENY;
  end

endmodule

// File: rtl/c2h_credit_gate.sv
module c2h_credit_gate
  import credit_gate_pkg::*;
#(
  parameter int NUM_Q  = 8,
  parameter int CRED_W = 16,
  localparam int QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [QW-1:0]     upd_qid,
  input  logic [CRED_W-1:0] upd_avail,
  input  logic              upd_c2h,
  input  logic              upd_stream,
  input  logic              upd_enable,
  input  logic              req_valid,
  input  logic [QW-1:0]     req_qid,
  output logic              req_ready,
  output logic              gnt_valid,
  output logic              deny_valid,
  output logic [QW-1:0]     rsp_qid
);

  localparam int NPORT = 2;   // port 0 serves updates, port 1 requests

  logic upd_app;
  assign upd_app   = upd_valid && upd_c2h && upd_stream;
  // Updates win the single write port; a request to another queue waits.
  assign req_ready = !(upd_app && upd_qid != req_qid);

  // Stage 1: sampled operation, memory read in flight.
  logic              s1_app, s1_en, s1_req;
  logic [QW-1:0]     s1_uq, s1_rq;
  logic [CRED_W-1:0] s1_avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_app <= 1'b0;
      s1_req <= 1'b0;
    end else begin
      s1_app <= upd_app;
      s1_req <= req_valid && req_ready;
    end
    s1_en    <= upd_enable;
    s1_uq    <= upd_qid;
    s1_rq    <= req_qid;
    s1_avail <= upd_avail;
  end

  // Write path and forwarding register.
  logic              wr_en;
  logic [QW-1:0]     wr_q;
  logic [CRED_W-1:0] wr_d;
  logic              fwd_en;
  logic [QW-1:0]     fwd_q;
  logic [CRED_W-1:0] fwd_d;
  logic [NUM_Q-1:0]  live;

  logic [QW-1:0]     rd_addr [NPORT];
  logic [QW-1:0]     s1_q    [NPORT];
  logic [CRED_W-1:0] rd_data [NPORT];
  logic [CRED_W-1:0] base    [NPORT];

  assign rd_addr[0] = upd_qid;
  assign rd_addr[1] = req_qid;
  assign s1_q[0]    = s1_uq;
  assign s1_q[1]    = s1_rq;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    credit_ram #(.DEPTH(NUM_Q), .WIDTH(CRED_W), .AW(QW)) u_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_q),
      .wdata (wr_d),
      .raddr (rd_addr[p]),
      .rdata (rd_data[p])
    );
    credit_fwd #(.CW(CRED_W), .QW(QW)) u_fwd (
      .live     (live[s1_q[p]]),
      .qid      (s1_q[p]),
      .rd_data  (rd_data[p]),
      .fwd_en   (fwd_en),
      .fwd_qid  (fwd_q),
      .fwd_data (fwd_d),
      .base     (base[p])
    );
  end

  rsp_e kind;

  credit_merge #(.CW(CRED_W), .QW(QW)) u_merge (
    .req    (s1_req),
    .app    (s1_app),
    .en     (s1_en),
    .uq     (s1_uq),
    .rq     (s1_rq),
    .avail  (s1_avail),
    .u_base (base[0]),
    .r_base (base[1]),
    .kind   (kind),
    .wr_en  (wr_en),
    .wr_q   (wr_q),
    .wr_d   (wr_d)
  );

  // Stage 2: write-back bookkeeping and registered responses.
  always_ff @(posedge clk) begin
    if (rst) begin
      live       <= '0;
      fwd_en     <= 1'b0;
      gnt_valid  <= 1'b0;
      deny_valid <= 1'b0;
      rsp_qid    <= '0;
    end else begin
      if (wr_en) live[wr_q] <= 1'b1;
      fwd_en     <= wr_en;
      gnt_valid  <= (kind == RSP_GRANT);
      deny_valid <= (kind == RSP_DENY);
      if (kind != RSP_NONE) rsp_qid <= s1_rq;
    end
    fwd_q <= wr_q;
    fwd_d <= wr_d;
  end

endmodule

// File: rtl/c2h_credit_gate_chk.sv
module c2h_credit_gate_chk #(
  parameter int NUM_Q = 8,
  localparam int QW   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [QW-1:0] req_qid,
  input logic          req_ready,
  input logic          gnt_valid,
  input logic          deny_valid,
  input logic [QW-1:0] rsp_qid
);

  // Edges seen out of reset, saturating; keeps $past inside reset history.
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)                age <= '0;
    else if (age != 2'd3)   age <= age + 2'd1;
  end

  // R11
  gnt_deny_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(gnt_valid && deny_valid));

  // R5
  acc_gets_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(req_valid && req_ready, 2)) |-> (gnt_valid || deny_valid));

  // R11
  rsp_needs_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid || deny_valid) |-> (age >= 2'd2 && $past(req_valid && req_ready, 2)));

  // R5
  rsp_qid_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && (gnt_valid || deny_valid)) |-> (rsp_qid == $past(req_qid, 2)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!gnt_valid && !deny_valid));

endmodule

bind c2h_credit_gate c2h_credit_gate_chk #(.NUM_Q(NUM_Q)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_qid    (req_qid),
  .req_ready  (req_ready),
  .gnt_valid  (gnt_valid),
  .deny_valid (deny_valid),
  .rsp_qid    (rsp_qid)
);

// File: tb/tb_c2h_credit_gate.sv
`timescale 1ns/1ps
module tb_c2h_credit_gate;

  localparam int NQ = 8;
  localparam int CW = 16;
  localparam int QW = 3;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          upd_valid = 0, upd_c2h = 0, upd_stream = 0, upd_enable = 0;
  logic [QW-1:0] upd_qid = '0;
  logic [CW-1:0] upd_avail = '0;
  logic          req_valid = 0;
  logic [QW-1:0] req_qid = '0;
  logic          req_ready, gnt_valid, deny_valid;
  logic [QW-1:0] rsp_qid;

  always #2 clk = ~clk;   // 250 MHz

  c2h_credit_gate #(.NUM_Q(NQ), .CRED_W(CW)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { bit g; int q; string tag; } exp_t;
  exp_t sb[$];
  exp_t e;
  int mdl [NQ];

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
    end
  endtask

  // Monitor: compares every response against the scoreboard.
  always @(posedge clk) begin
    #1;
    if (!rst && (gnt_valid || deny_valid)) begin
      chk(!(gnt_valid && deny_valid), "R11", "grant and deny together", 1, 0);
      if (sb.size() == 0) begin
        chk(0, "R11", "response without request", 1, 0);
      end else begin
        e = sb.pop_front();
        chk(gnt_valid == e.g, e.tag, "grant", gnt_valid, e.g);
        chk(int'(rsp_qid) == e.q, "R5", "rsp_qid", rsp_qid, e.q);
      end
    end
  end

  // Driver: one cycle of stimulus plus the expected outcome.
  task automatic step(input bit uv, input int uq, input int ua, input bit uc,
                      input bit us, input bit ue, input bit rv, input int rq,
                      input string tag);
    bit app, acc, g;
    int s;
    exp_t x;
    @(negedge clk);
    upd_valid = uv; upd_qid = uq[QW-1:0]; upd_avail = ua[CW-1:0];
    upd_c2h = uc; upd_stream = us; upd_enable = ue;
    req_valid = rv; req_qid = rq[QW-1:0];
    app = uv && uc && us;
    #0.5;
    // R8: arbitration against a different-queue update
    chk(req_ready == !(app && uq != rq), "R8", "req_ready", req_ready, !(app && uq != rq));
    acc = rv && !(app && uq != rq);
    g = acc && (mdl[rq] != 0);
    if (acc) begin
      x.g = g; x.q = rq; x.tag = tag;
      sb.push_back(x);
    end
    if (app) begin
      s = mdl[uq] + ua;
      if (s > MAXC) s = MAXC;
      mdl[uq] = ue ? s : 0;
    end
    if (g && !(app && uq == rq && !ue)) mdl[rq] = mdl[rq] - 1;
  endtask

  task automatic upd(input int q, input int a, input bit c, input bit st, input bit en);
    step(1, q, a, c, st, en, 0, 0, "R2");
  endtask

  task automatic req(input int q, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, q, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R11");
  endtask

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < NQ; i++) mdl[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #0.5;
    // R1: quiet outputs after reset
    chk(gnt_valid == 0, "R1", "gnt_valid after reset", gnt_valid, 0);
    chk(deny_valid == 0, "R1", "deny_valid after reset", deny_valid, 0);
    chk(req_ready == 1, "R1", "req_ready after reset", req_ready, 1);

    // R1: every queue starts empty
    for (int q = 0; q < NQ; q++) req(q, "R1");

    // R2 R6 R10: fill then drain back to back
    upd(2, 3, 1, 1, 1);
    req(2, "R10"); req(2, "R10"); req(2, "R10"); req(2, "R10");

    // R3: host-to-card and non-stream updates ignored
    upd(3, 5, 0, 1, 1);
    upd(4, 5, 1, 0, 1);
    idle(2);
    req(3, "R3"); req(4, "R3");

    // R2: saturation (a wrap would leave one credit)
    upd(5, 65535, 1, 1, 1);
    upd(5, 2, 1, 1, 1);
    req(5, "R2"); req(5, "R2"); req(5, "R2");

    // R4: invalidate clears
    upd(5, 9, 1, 1, 0);
    req(5, "R4");

    // R9: same-queue merge
    upd(6, 1, 1, 1, 1);
    step(1, 6, 2, 1, 1, 1, 1, 6, "R9");
    req(6, "R9"); req(6, "R9"); req(6, "R9");
    upd(6, 1, 1, 1, 1);
    step(1, 6, 4, 1, 1, 0, 1, 6, "R9");
    req(6, "R9");
    step(1, 7, 4, 1, 1, 1, 1, 7, "R6");
    for (int i = 0; i < 5; i++) req(7, "R10");

    // R8: update to another queue blocks the request
    upd(0, 1, 1, 1, 1);
    step(1, 1, 1, 1, 1, 1, 1, 0, "R8");
    step(1, 1, 1, 0, 1, 1, 1, 0, "R8");
    req(0, "R8"); req(1, "R8"); req(1, "R8");

    // R7: denials leave credit alone
    req(4, "R7"); req(4, "R7");
    upd(4, 1, 1, 1, 1);
    req(4, "R7"); req(4, "R7");

    // Mixed traffic against the model
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      for (int k = 0; k < 16; k++) lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] & lf[1], int'(lf[4:2]), int'(lf[7:5]), lf[8] | lf[9],
           lf[10] | lf[11], lf[12] | lf[13] | lf[14], lf[15] | lf[1],
           int'({lf[9], lf[6], lf[3]}), "R6");
    end

    idle(4);
    chk(sb.size() == 0, "R5", "responses outstanding", sb.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule